// File: doc/BRIEF.md
# Address-masked GPIO data port

This block is an 8-bit general-purpose I/O port on a simple single-cycle memory-mapped bus. It holds two registers: a data register, which drives the pad outputs, and a direction register, which drives the pad output enables. Pad inputs go through a two-stage synchronizer before any read can see them.

The data register appears at 256 word addresses. Byte-address bits [9:2] of each access form a per-bit mask. A write changes only the bits whose mask bit is set. A read returns zero for every bit whose mask bit is clear. Several independent software agents can therefore each own a subset of pins and update them with one store, with no read-modify-write sequence. For each unmasked bit, a read returns the stored value when the pin is an output and the synchronized pad level when it is an input.

The bus has a byte address, a write strobe with write data, and a read strobe. Read data is registered: it appears in the cycle after the read strobe is sampled and is zero in every other cycle.

Top module: `mgpio_port`

## Requirements
- R1: After reset, the data and direction registers are 0. As a result, pad_out and pad_oe are 0 and bus_rdata is 0.
- R2: A write to byte addresses 0x000–0x3FC updates data bit i only where address bit (i+2) is 1. Bits whose mask bit is 0 keep their value.
- R3: A read from the data window returns 0 in bit i whenever address bit (i+2) is 0, whatever the stored or pin value.
- R4: For an unmasked data bit whose direction bit is 1 (output), a read returns the stored data bit.
- R5: For an unmasked data bit whose direction bit is 0 (input), a read returns the pad level, delayed by a two-flop synchronizer. A pad change applied before clock edge k is first returned by a read sampled at edge k+2.
- R6: pad_out always equals the data register and pad_oe always equals the direction register, so a 1 in the direction register marks an output.
- R7: The direction register sits at byte address 0x400. Writes load bits 7:0 of the write data, and reads return it in bits 7:0 with bits 31:8 as 0.
- R8: Bits 31:8 of every read are 0. Bits 31:8 of the write data have no effect.
- R9: A read of any address outside the data window and 0x400 returns 0. A write there changes neither register.
- R10: Byte-address bits [1:0] have no effect on decoding or masking.
- R11: bus_rdata is registered. It holds the read result in the cycle after bus_re is sampled high and is 0 after any edge where bus_re is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
The assertions check these properties on every cycle:
- Masked write bits never change.
- Masked read bits are always zero.
- Reserved read bits stay zero.
- Out-of-range writes leave both registers alone.
- The direction register loads exactly the written byte.
- Read data returns to zero when no read is in flight.

Other behaviours depend on actual data values, and only the directed scenarios can show them:
- The choice between the stored bit and the pad level per direction bit.
- The exact two-edge synchronizer latency.
- The aliasing of the low address bits.
- The specific masked merge results.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Byte offset of the direction register
    localparam logic [31:0] DIR_BYTE_OFFSET = 32'h0000_0400;

    // Which register an access selects
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2
    } sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef logic [WIDTH-1:0] stage_t;

    stage_t stage_q [STAGES];
    stage_t stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_decode.sv
module gpio_decode
    import gpio_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned PORT_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [PORT_W-1:0] mask
);

    localparam int unsigned MASK_LO = 2;
    localparam int unsigned MASK_HI = MASK_LO + PORT_W - 1;
    localparam int unsigned WORD_W  = ADDR_W - MASK_LO;
    localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(DIR_BYTE_OFFSET >> MASK_LO);

    logic [WORD_W-1:0] word_addr;
    logic              in_data_window;
    logic              unused_lsb;

    assign word_addr      = addr[ADDR_W-1:MASK_LO];
    assign mask           = addr[MASK_HI:MASK_LO];
    assign in_data_window = (addr[ADDR_W-1:MASK_HI+1] == '0);
    assign unused_lsb     = ^addr[MASK_LO-1:0];

    always_comb begin
        if (in_data_window) begin
            sel = SEL_DATA;
        end else if (word_addr == DIR_WORD) begin
            sel = SEL_DIR;
        end else begin
            sel = SEL_NONE;
        end
    end

endmodule

// File: rtl/gpio_readmux.sv
module gpio_readmux
    import gpio_pkg::*;
#(
    parameter int unsigned PORT_W = 8,
    parameter int unsigned BUS_W  = 32
) (
    input  sel_e              sel,
    input  logic [PORT_W-1:0] mask,
    input  logic [PORT_W-1:0] data,
    input  logic [PORT_W-1:0] dir,
    input  logic [PORT_W-1:0] pin_sync,
    output logic [BUS_W-1:0]  rd_val
);

    logic [PORT_W-1:0] pin_view;

    // Per bit: stored value for outputs, pad level for inputs
    assign pin_view = (dir & data) | (~dir & pin_sync);

    always_comb begin
        rd_val = '0;
        unique case (sel)
            SEL_DATA: rd_val[PORT_W-1:0] = pin_view & mask;
            SEL_DIR:  rd_val[PORT_W-1:0] = dir;
            default:  rd_val = '0;
        endcase
    end

endmodule

// File: rtl/mgpio_port.sv
module mgpio_port
    import gpio_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned BUS_W       = 32,
    parameter int unsigned PORT_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_re,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe
);

    localparam int unsigned RSV_W = BUS_W - PORT_W;

    typedef struct packed {
        logic [PORT_W-1:0] data;
        logic [PORT_W-1:0] dir;
        logic [BUS_W-1:0]  rdata;
    } state_t;

    state_t            st_d, st_q;
    sel_e              sel;
    logic [PORT_W-1:0] mask;
    logic [PORT_W-1:0] pin_sync;
    logic [BUS_W-1:0]  rd_val;
    logic [PORT_W-1:0] wbyte;
    logic              unused_wdata_hi;

    assign wbyte           = bus_wdata[PORT_W-1:0];
    assign unused_wdata_hi = ^bus_wdata[BUS_W-1:PORT_W];

    gpio_sync #(
        .WIDTH  (PORT_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_decode #(
        .ADDR_W (ADDR_W),
        .PORT_W (PORT_W)
    ) u_decode (
        .addr (bus_addr),
        .sel  (sel),
        .mask (mask)
    );

    gpio_readmux #(
        .PORT_W (PORT_W),
        .BUS_W  (BUS_W)
    ) u_readmux (
        .sel      (sel),
        .mask     (mask),
        .data     (st_q.data),
        .dir      (st_q.dir),
        .pin_sync (pin_sync),
        .rd_val   (rd_val)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        if (bus_we) begin
            unique case (sel)
                SEL_DATA: st_d.data = (st_q.data & ~mask) | (wbyte & mask);
                SEL_DIR:  st_d.dir  = wbyte;
                default:  ;
            endcase
        end
        if (bus_re) begin
            st_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign pad_out   = st_q.data;
    assign pad_oe    = st_q.dir;

    // R2: masked-off data bits survive a data-window write
    p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_DATA) |=> (((st_q.data ^ $past(st_q.data)) & ~$past(mask)) == '0))
        else $error("p_mask_write_r2");

    // R3: masked-off bits read as zero
    p_read_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && sel == SEL_DATA) |=> ((bus_rdata[PORT_W-1:0] & ~$past(mask)) == '0))
        else $error("p_read_masked_r3");

    // R7: direction register loads the written byte
    p_dir_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_DIR) |=> (pad_oe == $past(wbyte)))
        else $error("p_dir_write_r7");

    // R8: reserved read bits are always zero
    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-1:PORT_W] == RSV_W'(0))
        else $error("p_reserved_zero_r8");

    // R9: writes outside both registers leave state alone
    p_miss_noeffect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_NONE) |=> ($stable(pad_out) && $stable(pad_oe)))
        else $error("p_miss_noeffect_r9");

    // R11: read data is zero after an edge with no read
    p_idle_rdata_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> (bus_rdata == '0))
        else $error("p_idle_rdata_r11");

endmodule

// File: tb/tb_mgpio_port.sv
`timescale 1ns/1ps
module tb_mgpio_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out;
    logic [7:0]  pad_oe;

    int n_checks = 0;
    int n_errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    mgpio_port dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(posedge clk);
        #1;
        d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    // Byte address whose mask bits [9:2] equal m
    function automatic logic [11:0] win(input logic [7:0] m);
        return {2'b00, m, 2'b00};
    endfunction

    task automatic t_reset();
        logic [31:0] r;
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 pad_out", {24'h0, pad_out}, 32'h0);
        check("R1 pad_oe", {24'h0, pad_oe}, 32'h0);
        bus_read(12'h400, r);
        check("R1 dir read", r, 32'h0);
    endtask

    task automatic t_dir();
        logic [31:0] r;
        bus_write(12'h400, 32'hABCD_00FF);
        check("R6 pad_oe", {24'h0, pad_oe}, 32'hFF);
        bus_read(12'h400, r);
        check("R7 dir read", r, 32'h0000_00FF);
    endtask

    task automatic t_mask_write();
        bus_write(win(8'hFF), 32'h0);
        bus_write(win(8'h0F), 32'hFF);
        check("R2 low nibble", {24'h0, pad_out}, 32'h0F);
        bus_write(win(8'hA0), 32'h5A);
        check("R2 mask A0 zeros", {24'h0, pad_out}, 32'h0F);
        bus_write(win(8'hA0), 32'hF0);
        check("R2 mask A0 ones", {24'h0, pad_out}, 32'hAF);
    endtask

    task automatic t_read_mask();
        logic [31:0] r;
        bus_read(win(8'h3C), r);
        check("R3 R4 masked read", r, 32'h2C);
        bus_read(win(8'h00), r);
        check("R3 zero mask", r, 32'h0);
        @(negedge clk);
        check("R11 idle rdata", bus_rdata, 32'h0);
    endtask

    task automatic t_inputs();
        logic [31:0] r;
        bus_write(12'h400, 32'h0F);
        pad_in = 8'h96;
        repeat (3) @(posedge clk);
        bus_read(win(8'hFF), r);
        check("R5 R4 mixed read", r, 32'h9F);
        check("R6 pad_out kept", {24'h0, pad_out}, 32'hAF);
        check("R6 pad_oe", {24'h0, pad_oe}, 32'h0F);
        @(negedge clk);
        pad_in = 8'h69;
        bus_addr = win(8'hFF); bus_re = 1'b1;
        @(posedge clk); #1;
        check("R5 latency edge1", bus_rdata, 32'h9F);
        @(posedge clk); #1;
        check("R5 latency edge2", bus_rdata, 32'h9F);
        @(posedge clk); #1;
        check("R5 latency edge3", bus_rdata, 32'h6F);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic t_lsb_alias();
        logic [31:0] r;
        bus_write(12'h3FF, 32'h0000_0003);
        check("R10 write low bits", {24'h0, pad_out}, 32'h03);
        bus_read(12'h3FD, r);
        check("R10 read low bits", r, 32'h63);
    endtask

    task automatic t_reserved();
        logic [31:0] r;
        bus_write(win(8'hFF), 32'hFFFF_FF00);
        check("R8 upper write ignored", {24'h0, pad_out}, 32'h00);
        bus_read(win(8'hFF), r);
        check("R8 upper read zero", r, 32'h60);
    endtask

    task automatic t_miss();
        logic [31:0] r;
        bus_write(12'h800, 32'hFF);
        bus_write(12'h404, 32'hFF);
        check("R9 pad_out kept", {24'h0, pad_out}, 32'h00);
        check("R9 pad_oe kept", {24'h0, pad_oe}, 32'h0F);
        bus_read(12'h800, r);
        check("R9 read 800", r, 32'h0);
        bus_read(12'h404, r);
        check("R9 read 404", r, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        t_reset();
        t_dir();
        t_mask_write();
        t_read_mask();
        t_inputs();
        t_lsb_alias();
        t_reserved();
        t_miss();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule